// File: doc/BRIEF.md
# I2C Register-Map Target

This block is an I2C target that gives a bus host read and write access to a small bank of byte registers. It follows the bus clock and data lines through synchronisers and finds start and stop conditions. It compares the 7-bit address in the first byte of a transfer against a fixed five-bit prefix `10010` joined to two strap bits. Once the address matches, a write transfer loads a register pointer from its first data byte. Any later bytes in that transfer are stored into the register bank.

A read transfer cannot load the pointer. The host therefore first sends a write that carries only the pointer byte and ends it with a stop, or with a repeated start. It then opens a read, and the bytes come back from the register that the pointer names. The top bit of the pointer byte turns on auto-increment, so that successive bytes move through consecutive registers. The target only ever pulls the data line low. It does this through an open-drain enable, to give acknowledge bits and read data.

Top module: `i2c_regmap_target`

## Requirements
- R1: A fall of SDA while SCL is high is taken as a start, and the target then waits for an address byte. A rise of SDA while SCL is high is taken as a stop, and the target then releases SDA and goes idle.
- R2: The first byte after a start holds the 7-bit address, MSB first, and then a direction bit (1 = read, 0 = write). If the address equals `10010` followed by the two latched strap bits, the target pulls SDA low during the ninth clock as an ACK.
- R3: The strap levels are sampled while reset is asserted and are held after reset is released. Later changes on the strap pins do not alter the address the target answers to.
- R4: When the address does not match, the target sends no ACK and keeps SDA released. It ignores every later bit until the next start or stop, and the register bank is left unchanged.
- R5: In a write, the byte after the address loads the pointer. The pointer's low bits select the register, taken as the pointer modulo REG_COUNT, so the index wraps from REG_COUNT-1 to 0. Bit 7 of that byte is the auto-increment flag. The target ACKs every byte it receives.
- R6: Each data byte of a write is stored at the pointed register. With auto-increment set, the next byte goes to the next register. With the flag clear, the pointer stays fixed, so the last byte of the transfer wins.
- R7: A read returns the register at the pointer left by an earlier write, MSB first, after that write was ended right after its pointer byte. With auto-increment set, each further byte comes from the next register. With the flag clear, the same register is returned each time.
- R8: When the host sends a NACK after a read byte, the read ends. The target then keeps SDA released for any further clocks until a start or stop.
- R9: The target changes its SDA drive only while SCL is low. It releases SDA during the ACK slot that the host owns in a read.
- R10: A repeated start in the middle of a transfer returns the target to address reception and leaves the pointer unchanged.
- R11: After reset, SDA is released and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; strap pins sampled while low |
| strap_i | input | 2 | Levels for the two low address bits |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |

## Verification
The assertions assume that the host obeys the bus rules. SDA changes only while SCL is low, except at start and stop. Each SCL level lasts far longer than the synchroniser delay. The host never tries to make a start or stop while the target is pulling SDA. The bench host holds every SCL phase for sixteen system clocks and drives all data while SCL is low. It makes its starts and stops only in slots where the target has released the line. A monitor running on every clock follows the same rule and compares the target's SDA drive with the SCL level it expects.

// File: rtl/i2c_rm_pkg.sv
package i2c_rm_pkg;
   localparam int BYTE_W = 8;
   localparam int PTR_W  = 7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_PTR,
      ST_WDATA,
      ST_RDATA
   } rm_state_e;
endpackage

// File: rtl/i2c_rm_sync.sv
module i2c_rm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_rm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2c_rm_bus_cond.sv
module i2c_rm_bus_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_hi_o,
   output logic scl_prev_o,
   output logic sda_lvl_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_s, sda_s, scl_q, sda_q;

   i2c_rm_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
   i2c_rm_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_hi_o   = scl_s;
   assign scl_prev_o = scl_q;
   assign sda_lvl_o  = sda_s;
   assign scl_rise_o = scl_s & ~scl_q;
   assign scl_fall_o = ~scl_s & scl_q;
   assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rm_regfile.sv
module i2c_rm_regfile
   import i2c_rm_pkg::*;
#(
   parameter int REG_COUNT = 16,
   localparam int IDX_W    = $clog2(REG_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  waddr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   input  logic [IDX_W-1:0]  raddr_i,
   output logic [BYTE_W-1:0] rdata_o
);
   logic [BYTE_W-1:0] regs [REG_COUNT];

   for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  regs[g] <= '0;
         else if (we_i && (waddr_i == IDX_W'(g)))     regs[g] <= wdata_i;
      end
   end

   assign rdata_o = regs[raddr_i];
endmodule

// File: rtl/i2c_regmap_target.sv
module i2c_regmap_target
   import i2c_rm_pkg::*;
#(
   parameter int         REG_COUNT   = 16,
   parameter int         SYNC_STAGES = 2,
   parameter logic [4:0] CHIP_PREFIX = 5'b10010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] strap_i,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_pull_o
);
   localparam int IDX_W = $clog2(REG_COUNT);

   if (REG_COUNT < 2 || REG_COUNT > 128 || (REG_COUNT & (REG_COUNT - 1)) != 0) begin : g_bad_count
      $error("i2c_regmap_target: REG_COUNT must be a power of two in 2..128");
   end

   logic scl_hi, scl_prev, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

   i2c_rm_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_hi_o(scl_hi), .scl_prev_o(scl_prev), .sda_lvl_o(sda_lvl),
      .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start_det), .stop_o(stop_det));

   rm_state_e         st;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] rx_sh, tx_sh;
   logic [PTR_W-1:0]  ptr;
   logic              inc, rd_dir, host_nack, pull;
   logic [1:0]        strap_q;
   logic [BYTE_W-1:0] rd_data;
   logic              wr_en, bus_evt;

   // strap levels are captured only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) strap_q <= strap_i;
   end

   assign bus_evt = start_det | stop_det;
   assign wr_en   = (st == ST_WDATA) && scl_fall && (bitcnt == 4'd8) && !bus_evt;

   i2c_rm_regfile #(.REG_COUNT(REG_COUNT)) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(wr_en),
      .waddr_i(ptr[IDX_W-1:0]), .wdata_i(rx_sh),
      .raddr_i(ptr[IDX_W-1:0]), .rdata_o(rd_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         bitcnt    <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         ptr       <= '0;
         inc       <= 1'b0;
         rd_dir    <= 1'b0;
         host_nack <= 1'b1;
         pull      <= 1'b0;
      end else if (start_det) begin
         st     <= ST_ADDR;
         bitcnt <= '0;
         pull   <= 1'b0;
      end else if (stop_det) begin
         st     <= ST_IDLE;
         bitcnt <= '0;
         pull   <= 1'b0;
      end else if (st != ST_IDLE) begin
         if (scl_rise) begin
            if (bitcnt < 4'd8) begin
               bitcnt <= bitcnt + 4'd1;
               if (st != ST_RDATA) rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
            end else if (bitcnt == 4'd8) begin
               bitcnt <= 4'd9;
               if (st == ST_RDATA) host_nack <= sda_lvl;
            end
         end else if (scl_fall) begin
            if (st == ST_RDATA) begin
               if (bitcnt >= 4'd1 && bitcnt < 4'd8) begin
                  tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                  pull  <= ~tx_sh[BYTE_W-2];
               end else if (bitcnt == 4'd8) begin
                  pull <= 1'b0;
               end else if (bitcnt == 4'd9) begin
                  if (!host_nack) begin
                     tx_sh  <= rd_data;
                     pull   <= ~rd_data[BYTE_W-1];
                     ptr    <= ptr + PTR_W'(inc);
                     bitcnt <= '0;
                  end else begin
                     st   <= ST_IDLE;
                     pull <= 1'b0;
                  end
               end
            end else if (bitcnt == 4'd8) begin
               unique case (st)
                  ST_ADDR: begin
                     if (rx_sh[BYTE_W-1:1] == {CHIP_PREFIX, strap_q}) begin
                        pull   <= 1'b1;
                        rd_dir <= rx_sh[0];
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
                  ST_PTR: begin
                     ptr  <= rx_sh[PTR_W-1:0];
                     inc  <= rx_sh[BYTE_W-1];
                     pull <= 1'b1;
                  end
                  ST_WDATA: begin
                     ptr  <= ptr + PTR_W'(inc);
                     pull <= 1'b1;
                  end
                  default: ;
               endcase
            end else if (bitcnt == 4'd9) begin
               bitcnt <= '0;
               pull   <= 1'b0;
               unique case (st)
                  ST_ADDR: begin
                     if (rd_dir) begin
                        st     <= ST_RDATA;
                        tx_sh  <= rd_data;
                        pull   <= ~rd_data[BYTE_W-1];
                        ptr    <= ptr + PTR_W'(inc);
                     end else begin
                        st <= ST_PTR;
                     end
                  end
                  ST_PTR:  st <= ST_WDATA;
                  default: ;
               endcase
            end
         end
      end
   end

   assign sda_pull_o = pull;

   // drive changes only while the bus clock is low (R9)
   p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_hi && scl_prev) |=> $stable(sda_pull_o));
   // idle or unmatched target keeps the line released (R4)
   p_idle_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_pull_o);
   // a start leaves the pointer untouched (R10)
   p_ptr_kept_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> $stable(ptr));
   // no bank write while sending read data (R7)
   p_no_write_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RDATA) |-> !wr_en);
   // pointer fixed across data bytes with increment off (R6)
   p_ptr_fixed_noinc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !inc) |=> $stable(ptr));
   // bit counter never passes the acknowledge slot (R2)
   p_bitcnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= 4'd9);
endmodule

// File: tb/i2c_regmap_target_tb.sv
module i2c_regmap_target_tb;
   localparam int H = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] strap = 2'b10;
   logic scl = 1'b1;
   logic sda_drv = 1'b1;
   wire  sda_pull;
   wire  sda_line = sda_drv & ~sda_pull;

   int n_chk = 0;
   int n_bad = 0;
   int mon_bad = 0;
   bit done = 0;
   logic [7:0] mem [16];

   always #2 clk = ~clk;

   i2c_regmap_target u_dut (
      .clk(clk), .rst_n(rst_n), .strap_i(strap),
      .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull));

   // per-clock reference: with the host's SCL held high, drive must not move (R9)
   logic scl_prev = 1'b1, pull_prev = 1'b0;
   always @(posedge clk) begin
      #1;
      if (rst_n && scl && scl_prev && (sda_pull !== pull_prev)) mon_bad++;
      scl_prev  = scl;
      pull_prev = sda_pull;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start();
      sda_drv = 1'b1; hc(H);
      scl = 1'b1;     hc(H);
      sda_drv = 1'b0; hc(H);
      scl = 1'b0;     hc(H);
   endtask

   task automatic do_stop();
      sda_drv = 1'b0; hc(H);
      scl = 1'b1;     hc(H);
      sda_drv = 1'b1; hc(H);
   endtask

   task automatic put_bit(input logic b);
      sda_drv = b; hc(H);
      scl = 1'b1;  hc(H);
      scl = 1'b0;  hc(2);
   endtask

   task automatic get_bit(output logic b);
      sda_drv = 1'b1; hc(H);
      scl = 1'b1;     hc(H / 2);
      b = sda_line;   hc(H / 2);
      scl = 1'b0;     hc(2);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      acked = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] v, input logic host_ack);
      for (int i = 7; i >= 0; i--) get_bit(v[i]);
      sda_drv = ~host_ack; hc(H);
      scl = 1'b1;          hc(H / 2);
      chk("R9 released in host ack slot", sda_pull, 1'b0);
      hc(H / 2);
      scl = 1'b0;          hc(2);
   endtask

   task automatic set_ptr(input logic [7:0] p);
      logic a;
      do_start();
      send_byte(8'h94, a); chk("R2 write address ack", a, 1'b1);
      send_byte(p, a);     chk("R5 pointer byte ack", a, 1'b1);
      do_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
         $finish;
      end
   end

   initial begin
      logic a;
      logic [7:0] d;
      for (int i = 0; i < 16; i++) mem[i] = 8'h00;
      hc(10);
      rst_n = 1'b1;
      hc(4);
      strap = 2'b01;
      hc(4);
      chk("R11 sda released after reset", sda_pull, 1'b0);

      // R11 register reset value, read reg 9
      set_ptr(8'h09);
      do_start(); send_byte(8'h95, a); chk("R2 read address ack", a, 1'b1);
      recv_byte(d, 1'b0); chk("R11 register resets to zero", d, 8'h00);
      do_stop();

      // R6 write with auto-increment
      do_start();
      send_byte(8'h94, a); chk("R2 address ack", a, 1'b1);
      send_byte(8'h83, a); chk("R5 pointer ack", a, 1'b1);
      send_byte(8'hA1, a); chk("R6 data ack", a, 1'b1);
      send_byte(8'hB2, a); chk("R6 data ack", a, 1'b1);
      send_byte(8'hC3, a); chk("R6 data ack", a, 1'b1);
      do_stop();
      mem[3] = 8'hA1; mem[4] = 8'hB2; mem[5] = 8'hC3;

      // R3 address built from new strap levels must not answer
      do_start();
      send_byte(8'h92, a); chk("R3 strap held from reset", a, 1'b0);
      do_stop();

      // R6 write without increment: last byte wins
      do_start();
      send_byte(8'h94, a); send_byte(8'h07, a);
      send_byte(8'h11, a); send_byte(8'h22, a); chk("R6 data ack", a, 1'b1);
      do_stop();
      mem[7] = 8'h22;

      // R7 read with increment, R8 nack ends read
      set_ptr(8'h83);
      do_start(); send_byte(8'h95, a); chk("R2 read ack", a, 1'b1);
      recv_byte(d, 1'b1); chk("R7 read first", d, mem[3]);
      recv_byte(d, 1'b1); chk("R7 read incremented", d, mem[4]);
      recv_byte(d, 1'b0); chk("R7 read third", d, mem[5]);
      recv_byte(d, 1'b0); chk("R8 silent after nack", d, 8'hFF);
      do_stop();

      // R7 read without increment repeats one register
      set_ptr(8'h07);
      do_start(); send_byte(8'h95, a);
      recv_byte(d, 1'b1); chk("R7 fixed pointer read", d, mem[7]);
      recv_byte(d, 1'b0); chk("R7 fixed pointer repeat", d, mem[7]);
      do_stop();

      // R4 mismatched address ignored entirely
      do_start();
      send_byte(8'h90, a); chk("R4 no ack on mismatch", a, 1'b0);
      send_byte(8'h80, a); chk("R4 ignored byte", a, 1'b0);
      send_byte(8'h5A, a); chk("R4 ignored byte", a, 1'b0);
      do_stop();
      set_ptr(8'h00);
      do_start(); send_byte(8'h95, a);
      recv_byte(d, 1'b0); chk("R4 bank unchanged", d, mem[0]);
      do_stop();

      // R10 repeated start after pointer keeps it
      do_start();
      send_byte(8'h94, a); send_byte(8'h85, a);
      do_start();
      send_byte(8'h95, a); chk("R10 address after repeated start", a, 1'b1);
      recv_byte(d, 1'b0); chk("R10 pointer kept", d, mem[5]);
      do_stop();

      // R10 repeated start after an incremented data write
      do_start();
      send_byte(8'h94, a); send_byte(8'h86, a); send_byte(8'h77, a);
      mem[6] = 8'h77;
      do_start();
      send_byte(8'h95, a);
      recv_byte(d, 1'b0); chk("R10 advanced pointer kept", d, mem[7]);
      do_stop();

      // R5 index wraps at the end of the bank
      do_start();
      send_byte(8'h94, a); send_byte(8'h8F, a);
      send_byte(8'hDD, a); send_byte(8'hEE, a);
      do_stop();
      mem[15] = 8'hDD; mem[0] = 8'hEE;
      set_ptr(8'h8F);
      do_start(); send_byte(8'h95, a);
      recv_byte(d, 1'b1); chk("R5 last register", d, mem[15]);
      recv_byte(d, 1'b0); chk("R5 wrapped to first", d, mem[0]);
      do_stop();

      // R1 start/stop: after stop the line is released
      hc(8);
      chk("R1 released after stop", sda_pull, 1'b0);
      chk("R9 drive stable while SCL high", mon_bad, 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule